// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte is written into a one-entry holding register. When the transmit enable is set, the byte moves into a shift register and leaves the line as a frame. The frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or more high stop bits. The line rests high between frames.

A mode byte sets the frame format:
- the character length,
- whether parity is used and which sense it has,
- the stop period,
- how many transmit clock-enable ticks make up one bit.

A break control forces the line low whenever it is set. Two status outputs report whether another byte can be written (ready) and whether the transmitter has fully drained (empty). Because the holding register is emptied at the start of each frame, a host can keep one byte queued ahead. Frames then follow each other with no idle gap.

The mode byte must stay stable while the transmitter is not empty.

Top module: `serialFrameTx`

## Requirements
- R1: After reset the line is high (1), and both txReady and txEmpty are 1.
- R2: A frame is sent as follows. The start bit is 0, lasting one bit time. Then the data bits follow, least significant bit first, each lasting one bit time. The number of data bits is 5 + modeByte[3:2], so 00=5, 01=6, 10=7 and 11=8. Last come the stop bits at 1. The line is 1 when no frame is in progress.
- R3: modeByte[4]=1 inserts one parity bit of one bit time after the data bits. modeByte[5]=1 makes the count of ones over the data and parity bits even; modeByte[5]=0 makes it odd.
- R4: modeByte[7:6] selects the stop period: 01 gives 1 bit time, 10 gives 1.5 bit times, 11 gives 2 bit times. The value 00 is treated as 1 bit time.
- R5: modeByte[1:0] selects the ticks of tickEn per bit: 01 gives 1, 10 gives 16, 11 gives 64. The value 00 is treated as 1. The 1.5 stop period lasts 24 ticks at 16 ticks per bit and 96 ticks at 64 ticks per bit. At 1 tick per bit it is rounded up to 2 ticks. Bit timing advances only on clock cycles with tickEn=1.
- R6: A frame starts only while txEnable=1. A byte written while txEnable=0 waits in the holding register, and the line stays 1.
- R7: While sendBreak=1 the line is 0. Frame timing continues unchanged underneath, and the line follows the frame again once sendBreak returns to 0.
- R8: txReady is 1 exactly when the holding register is free. It returns to 1 the cycle after a frame starts. A write (wrValid=1) while txReady=0 is ignored.
- R9: txEmpty is 1 only when neither the holding register nor the shift register holds a byte. It rises the cycle after the last stop tick.
- R10: If a byte is waiting and txEnable=1 when the last stop tick completes, the next start bit begins on the following cycle, with no idle bit time between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Transmit clock-enable tick |
| modeByte | input | 8 | Frame format: [1:0] ticks per bit, [3:2] length, [4] parity on, [5] even parity, [7:6] stop period |
| txEnable | input | 1 | Allows frames to start |
| sendBreak | input | 1 | Forces the line low |
| wrValid | input | 1 | Write strobe for wrData |
| wrData | input | 8 | Byte to transmit |
| txReady | output | 1 | Holding register is free |
| txEmpty | output | 1 | No byte held or in flight |
| txLine | output | 1 | Serial output, idles high |

## Verification
A table of mode and data pairs drives the main function. The pairs cover:
- every character length;
- no parity, even parity and odd parity, with data whose one-count gives each parity value;
- every stop setting, including the invalid code and the rounded 1.5 stop period at one tick per bit;
- all three tick factors.

Every cycle of every frame is compared against a waveform built from the mode fields. A fault in bit order, masking, parity sense or stop length therefore shows up at the exact bit that differs. Directed patterns then cover:
- a byte held back by a low enable, with a second write that must be dropped;
- two frames sent back to back, which shows whether the gapless hand-off is present;
- a break asserted in the middle of an all-ones byte, which separates forcing the line low from disturbing the frame's timing.

// File: rtl/serTxPkg.sv
package serTxPkg;
  localparam int MODE_W = 8;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_START,
    LINE_DATA,
    LINE_PARITY
  } lineSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } txStrobe_t;
endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int MID_FACTOR  = 16,
  parameter int HIGH_FACTOR = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [MODE_W-1:0] modeByte,
  input  logic              txEnable,
  input  logic              holdFull,
  output txStrobe_t         strobe,
  output logic              ctrlIdle
);
  localparam int CNT_W = $clog2(2 * HIGH_FACTOR + 1);

  txState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitIdx;
  logic [CNT_W-1:0] bitTicks;
  logic [CNT_W-1:0] stopTicks;
  logic [CNT_W-1:0] curLen;
  logic [2:0]       lastIdx;
  logic             bitDone;
  logic             canLoad;

  always_comb begin
    case (modeByte[1:0])
      2'b10:   bitTicks = CNT_W'(MID_FACTOR);
      2'b11:   bitTicks = CNT_W'(HIGH_FACTOR);
      default: bitTicks = CNT_W'(1);
    endcase
    case (modeByte[7:6])
      2'b10:   stopTicks = (bitTicks == CNT_W'(1)) ? CNT_W'(2)
                                                  : bitTicks + (bitTicks >> 1);
      2'b11:   stopTicks = bitTicks << 1;
      default: stopTicks = bitTicks;
    endcase
  end

  assign curLen  = (state == ST_STOP) ? stopTicks : bitTicks;
  assign bitDone = tickEn && (tickCnt == curLen - CNT_W'(1));
  assign lastIdx = 3'(3'd4 + {1'b0, modeByte[3:2]});
  assign canLoad = holdFull && txEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (canLoad) state <= ST_START;
        end
        ST_START: begin
          if (bitDone) begin
            state   <= ST_DATA;
            bitIdx  <= '0;
            tickCnt <= '0;
          end else if (tickEn) begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (bitDone) begin
            tickCnt <= '0;
            if (bitIdx == lastIdx) state <= modeByte[4] ? ST_PARITY : ST_STOP;
            else bitIdx <= bitIdx + 3'd1;
          end else if (tickEn) begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        ST_PARITY: begin
          if (bitDone) begin
            state   <= ST_STOP;
            tickCnt <= '0;
          end else if (tickEn) begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (bitDone) begin
            tickCnt <= '0;
            state   <= canLoad ? ST_START : ST_IDLE;
          end else if (tickEn) begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = canLoad && ((state == ST_IDLE) || (state == ST_STOP && bitDone));
    strobe.shift = (state == ST_DATA) && bitDone;
    case (state)
      ST_START:  strobe.lineSel = LINE_START;
      ST_DATA:   strobe.lineSel = LINE_DATA;
      ST_PARITY: strobe.lineSel = LINE_PARITY;
      default:   strobe.lineSel = LINE_MARK;
    endcase
  end

  assign ctrlIdle = (state == ST_IDLE);

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !txEnable) |=> state == ST_IDLE) else $error("start while disabled"); // R6
  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < curLen) else $error("tick counter overran bit time"); // R5
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && state != ST_IDLE) |=> $stable(tickCnt)) else $error("timing moved without tick"); // R5
endmodule

// File: rtl/serTxData.sv
module serTxData
  import serTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              wrValid,
  input  logic [CHAR_W-1:0] wrData,
  input  logic [1:0]        lenSel,
  input  logic              parityEven,
  input  logic              sendBreak,
  output logic              holdFull,
  output logic              txLine
);
  logic [CHAR_W-1:0] holdData;
  logic [CHAR_W-1:0] shiftReg;
  logic [CHAR_W-1:0] charMask;
  logic              parityBit;
  logic              nextParity;
  logic              frameLine;

  assign charMask   = {CHAR_W{1'b1}} >> (2'd3 - lenSel);
  assign nextParity = parityEven ? ^(holdData & charMask) : ~^(holdData & charMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData  <= '0;
      holdFull  <= 1'b0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strobe.load) begin
        shiftReg  <= holdData;
        parityBit <= nextParity;
        holdFull  <= 1'b0;
      end else if (wrValid && !holdFull) begin
        holdData <= wrData;
        holdFull <= 1'b1;
      end
      if (strobe.shift) shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_START:  frameLine = 1'b0;
      LINE_DATA:   frameLine = shiftReg[0];
      LINE_PARITY: frameLine = parityBit;
      default:     frameLine = 1'b1;
    endcase
  end

  assign txLine = sendBreak ? 1'b0 : frameLine;

  AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !holdFull) else $error("holding register not freed"); // R8
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !strobe.load) |=> $stable(holdData)) else $error("write overwrote held byte"); // R8
endmodule

// File: rtl/serialFrameTx.sv
module serialFrameTx
  import serTxPkg::*;
#(
  parameter int MID_FACTOR  = 16,
  parameter int HIGH_FACTOR = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [7:0] modeByte,
  input  logic       txEnable,
  input  logic       sendBreak,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  output logic       txReady,
  output logic       txEmpty,
  output logic       txLine
);
  txStrobe_t strobe;
  logic      holdFull;
  logic      ctrlIdle;

  serTxCtrl #(
    .MID_FACTOR (MID_FACTOR),
    .HIGH_FACTOR(HIGH_FACTOR)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .modeByte(modeByte),
    .txEnable(txEnable),
    .holdFull(holdFull),
    .strobe  (strobe),
    .ctrlIdle(ctrlIdle)
  );

  serTxData data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrValid   (wrValid),
    .wrData    (wrData),
    .lenSel    (modeByte[3:2]),
    .parityEven(modeByte[5]),
    .sendBreak (sendBreak),
    .holdFull  (holdFull),
    .txLine    (txLine)
  );

  assign txReady = !holdFull;
  assign txEmpty = !holdFull && ctrlIdle;

  AST_EMPTY_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txReady) else $error("empty without ready"); // R9
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txLine) else $error("break not forcing low"); // R7
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !sendBreak) |-> txLine) else $error("idle line not high"); // R1
endmodule

// File: tb/tb_serialFrameTx.sv
`timescale 1ns/1ps
module tb_serialFrameTx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic [7:0] modeByte = 8'h4D;
  logic       txEnable = 1'b0;
  logic       sendBreak = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txReady, txEmpty, txLine;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  serialFrameTx dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeByte(modeByte),
    .txEnable(txEnable), .sendBreak(sendBreak), .wrValid(wrValid),
    .wrData(wrData), .txReady(txReady), .txEmpty(txEmpty), .txLine(txLine)
  );

  // {mode, data}
  localparam logic [15:0] VEC [7] = '{
    {8'h4D, 8'hA5},  // 8 bits, no parity, 1 stop, 1x
    {8'h79, 8'h35},  // 7 bits, even, 1 stop, 1x
    {8'hD1, 8'h1F},  // 5 bits, odd, 2 stop, 1x
    {8'hB6, 8'h2C},  // 6 bits, even, 1.5 stop, 16x
    {8'h9D, 8'h80},  // 8 bits, odd, 1.5 stop, 1x (rounds to 2)
    {8'h4F, 8'h5A},  // 8 bits, no parity, 1 stop, 64x
    {8'h0C, 8'hC3}   // invalid stop and factor codes
  };

  function automatic int bitTicks(input logic [7:0] m);
    case (m[1:0])
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 1;
    endcase
  endfunction

  function automatic int stopTicks(input logic [7:0] m);
    int b = bitTicks(m);
    case (m[7:6])
      2'b10:   return (b == 1) ? 2 : b + b / 2;
      2'b11:   return 2 * b;
      default: return b;
    endcase
  endfunction

  function automatic int frameLen(input logic [7:0] m);
    return bitTicks(m) * (1 + 5 + int'(m[3:2]) + int'(m[4])) + stopTicks(m);
  endfunction

  function automatic logic frameBit(input logic [7:0] m, input logic [7:0] d, input int k);
    int   idx = k / bitTicks(m);
    int   n   = 5 + int'(m[3:2]);
    logic p   = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ d[i];
    if (!m[5]) p = ~p;
    if (idx == 0) return 1'b0;
    if (idx <= n) return d[idx-1];
    if (m[4] && idx == n + 1) return p;
    return 1'b1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitFall();
    int n = 0;
    while (txLine !== 1'b0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkFrame(input logic [7:0] m, input logic [7:0] d, input string tag);
    int len = frameLen(m);
    int bad = -1;
    logic badAct = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (bad < 0 && txLine !== frameBit(m, d, k)) begin
        bad = k;
        badAct = txLine;
      end
      @(negedge clk);
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s waveform cycle %0d actual=%0b expected=%0b", tag, bad, badAct,
               frameBit(m, d, bad));
    end
    check({tag, " R9 empty after frame"}, txEmpty, 1'b1);
    check({tag, " R2 line idle after frame"}, txLine, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 line", txLine, 1'b1);
    check("R1 ready", txReady, 1'b1);
    check("R1 empty", txEmpty, 1'b1);
    rstN = 1'b1;
    txEnable = 1'b1;

    // table of formats: R2 R3 R4 R5
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      modeByte = VEC[i][15:8];
      writeByte(VEC[i][7:0]);
      waitFall();
      checkFrame(VEC[i][15:8], VEC[i][7:0], $sformatf("R2 R3 R4 R5 entry %0d", i));
    end

    // R6 and R8: held byte, ignored second write
    @(negedge clk);
    modeByte = 8'h4D;
    txEnable = 1'b0;
    writeByte(8'h11);
    writeByte(8'h22);
    repeat (6) @(negedge clk);
    check("R6 line stays high while disabled", txLine, 1'b1);
    check("R8 ready low while byte held", txReady, 1'b0);
    check("R9 not empty while byte held", txEmpty, 1'b0);
    txEnable = 1'b1;
    waitFall();
    checkFrame(8'h4D, 8'h11, "R8 ignored write keeps first byte");

    // R10 back to back frames
    writeByte(8'hA5);
    waitFall();
    check("R8 ready returns after frame start", txReady, 1'b1);
    for (int k = 0; k < 20; k++) begin
      logic e;
      e = (k < 10) ? frameBit(8'h4D, 8'hA5, k) : frameBit(8'h4D, 8'h3C, k - 10);
      check($sformatf("R10 back-to-back cycle %0d", k), txLine, e);
      if (k == 0) begin
        wrValid = 1'b1;
        wrData  = 8'h3C;
      end else begin
        wrValid = 1'b0;
      end
      @(negedge clk);
    end
    check("R10 empty after second frame", txEmpty, 1'b1);

    // R7 break while idle and mid-frame
    sendBreak = 1'b1;
    #1;
    check("R7 break low while idle", txLine, 1'b0);
    sendBreak = 1'b0;
    #1;
    check("R7 line high after break", txLine, 1'b1);
    writeByte(8'hFF);
    waitFall();
    repeat (3) @(negedge clk);
    sendBreak = 1'b1;
    @(negedge clk);
    check("R7 break low mid-frame", txLine, 1'b0);
    sendBreak = 1'b0;
    @(negedge clk);
    check("R7 frame data back after break", txLine, 1'b1);
    check("R7 frame still busy", txEmpty, 1'b0);
    repeat (5) @(negedge clk);
    check("R7 frame length unchanged by break", txEmpty, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule